// File: doc/BRIEF.md
# Double-Precision NaN Classifier and Quieter

This unit accepts one 64-bit double-precision operand per handshake and tells whether it is a NaN and, if so, whether that NaN is signaling. A per-operand mode input selects how the top fraction bit is read. In the 2008 convention a set top bit marks a quiet NaN. In the legacy convention the same bit marks a signaling NaN. When a quiet request comes with a signaling NaN, the unit returns a quieted copy of the operand and raises a sticky invalid-operation flag. The flag stays set until a dedicated clear input drops it.

Operands enter through a valid/ready port. Each result leaves through a valid/ready port one clock after it was accepted. A two-state controller owns a single output slot, named EMPTY and HOLD. It moves EMPTY->HOLD on an accept (`fill`). It stays in HOLD when a new operand arrives while the old result drains (`refill`) or when the consumer stalls (`stall`). It moves HOLD->EMPTY when the result drains and nothing new arrives (`drain`). From EMPTY it stays in EMPTY when nothing arrives (`idle`).

A quiet request on an operand that is not a signaling NaN is a usage error and must not happen. If it does happen, the operand passes through unchanged and the flag is left alone.

Top module: `nanq_unit`

## Requirements
- R1: While reset is asserted, out_valid and out_invalid are 0 and in_ready is 1.
- R2: out_is_nan is 1 exactly when the exponent field (bits 62:52) is all ones and the fraction field (bits 51:0) is nonzero.
- R3: out_is_snan is 1 exactly when the operand is a NaN and fraction bit 51 XOR the 2008-mode bit equals 1.
- R4: When no quiet is applied, out_data equals the accepted operand bit for bit. This covers infinities, zeros, normal numbers and NaNs.
- R5: Quieting in 2008 mode sets fraction bit 51 and leaves every other bit unchanged, including the sign (bit 63) and the exponent.
- R6: Quieting in legacy mode clears fraction bit 51. If the fraction is then all zero, it also sets fraction bit 50. All other bits stay unchanged.
- R7: Accepting a quiet request with a signaling NaN sets out_invalid. The flag stays set until clr_invalid is high at a clock edge. When a set and a clear meet at the same edge, the set wins. Quiet is requested only with signaling NaNs.
- R8: A result appears on out_valid at the first clock edge after its operand is accepted. While out_valid is high and out_ready is low, all result outputs hold their values.
- R9: in_ready equals (not out_valid) or out_ready. An operand offered while the slot is full and stalled is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offer |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_data | input | 64 | Operand: sign 63, exponent 62:52, fraction 51:0 |
| in_quiet | input | 1 | Request a quieted copy of a signaling NaN |
| in_mode2008 | input | 1 | 1 = 2008 NaN convention, 0 = legacy |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Operand or its quieted copy |
| out_is_nan | output | 1 | Accepted operand was a NaN |
| out_is_snan | output | 1 | Accepted operand was a signaling NaN under its mode |
| clr_invalid | input | 1 | Clear the sticky invalid flag |
| out_invalid | output | 1 | Sticky invalid-operation flag |

## Verification
The checker assumes that in_quiet is high only while in_valid carries a signaling NaN under the mode presented with it. It checks this from its own decode of in_data. The bench keeps to this rule: both the vector table and the random phase raise the quiet request only after the bench's own model has classified the operand as signaling. A stalled offer with a quiet request is also used only with a signaling operand. The clear input is driven freely, including in the same cycle as a quiet accept, because the unit defines priority for that case.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

    localparam int unsigned DP_EXP_W  = 11;
    localparam int unsigned DP_FRAC_W = 52;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } slot_state_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } nan_class_t;

endpackage

// File: rtl/nanq_classify.sv
module nanq_classify #(
    parameter int unsigned EXP_W  = nanq_pkg::DP_EXP_W,
    parameter int unsigned FRAC_W = nanq_pkg::DP_FRAC_W
) (
    input  logic [EXP_W-1:0]    exp_field,
    input  logic [FRAC_W-1:0]   frac_field,
    input  logic                mode2008,
    output nanq_pkg::nan_class_t cls
);
    localparam int unsigned QBIT = FRAC_W - 1;

    logic exp_all_ones;
    logic frac_nonzero;
    logic top_bit_says_signal;

    always_comb begin
        exp_all_ones        = &exp_field;
        frac_nonzero        = |frac_field;
        top_bit_says_signal = frac_field[QBIT] ^ mode2008;
        cls.is_nan          = exp_all_ones & frac_nonzero;
        cls.is_snan         = exp_all_ones & frac_nonzero & top_bit_says_signal;
    end

endmodule

// File: rtl/nanq_quieter.sv
module nanq_quieter #(
    parameter int unsigned FRAC_W = nanq_pkg::DP_FRAC_W
) (
    input  logic [FRAC_W-1:0] frac_in,
    input  logic              mode2008,
    input  logic              apply,
    output logic [FRAC_W-1:0] frac_out
);
    localparam int unsigned QBIT = FRAC_W - 1;
    localparam logic [FRAC_W-1:0] QMASK = FRAC_W'(1) << QBIT;

    logic [FRAC_W-1:0] frac_2008;
    logic [FRAC_W-1:0] frac_cleared;
    logic [FRAC_W-1:0] frac_legacy;

    always_comb begin
        frac_2008    = frac_in | QMASK;
        frac_cleared = frac_in & ~QMASK;
    end

    generate
        if (FRAC_W >= 2) begin : g_repair
            localparam logic [FRAC_W-1:0] RMASK = FRAC_W'(1) << (QBIT - 1);
            always_comb begin
                if (frac_cleared == '0) begin
                    frac_legacy = frac_cleared | RMASK;
                end else begin
                    frac_legacy = frac_cleared;
                end
            end
        end else begin : g_no_repair
            always_comb frac_legacy = frac_cleared;
        end
    endgenerate

    always_comb begin
        if (!apply) begin
            frac_out = frac_in;
        end else if (mode2008) begin
            frac_out = frac_2008;
        end else begin
            frac_out = frac_legacy;
        end
    end

endmodule

// File: rtl/nanq_ctrl.sv
module nanq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic load,
    output logic out_valid
);
    import nanq_pkg::*;

    slot_state_e state_q;
    slot_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        load      = in_valid && in_ready;
        out_valid = (state_q == ST_HOLD);
        state_d   = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (load) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (out_ready && !load) begin
                    state_d = ST_EMPTY;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

endmodule

// File: rtl/nanq_sticky.sv
module nanq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/nanq_unit.sv
module nanq_unit #(
    parameter int unsigned EXP_W  = nanq_pkg::DP_EXP_W,
    parameter int unsigned FRAC_W = nanq_pkg::DP_FRAC_W,
    localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [OP_W-1:0] in_data,
    input  logic            in_quiet,
    input  logic            in_mode2008,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [OP_W-1:0] out_data,
    output logic            out_is_nan,
    output logic            out_is_snan,
    input  logic            clr_invalid,
    output logic            out_invalid
);
    import nanq_pkg::*;

    logic                 op_sign;
    logic [EXP_W-1:0]     op_exp;
    logic [FRAC_W-1:0]    op_frac;
    logic [FRAC_W-1:0]    res_frac;
    nan_class_t           op_cls;
    nan_class_t           cls_q;
    logic                 apply_quiet;
    logic                 load;
    logic [OP_W-1:0]      data_q;

    always_comb begin
        op_sign     = in_data[OP_W-1];
        op_exp      = in_data[OP_W-2:FRAC_W];
        op_frac     = in_data[FRAC_W-1:0];
        apply_quiet = in_quiet && op_cls.is_snan;
    end

    nanq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .exp_field (op_exp),
        .frac_field(op_frac),
        .mode2008  (in_mode2008),
        .cls       (op_cls)
    );

    nanq_quieter #(.FRAC_W(FRAC_W)) u_quieter (
        .frac_in (op_frac),
        .mode2008(in_mode2008),
        .apply   (apply_quiet),
        .frac_out(res_frac)
    );

    nanq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .load     (load),
        .out_valid(out_valid)
    );

    nanq_sticky u_invalid (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (load && apply_quiet),
        .clr  (clr_invalid),
        .flag (out_invalid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cls_q  <= '0;
        end else if (load) begin
            data_q <= {op_sign, op_exp, res_frac};
            cls_q  <= op_cls;
        end
    end

    always_comb begin
        out_data    = data_q;
        out_is_nan  = cls_q.is_nan;
        out_is_snan = cls_q.is_snan;
    end

endmodule

// File: rtl/nanq_unit_chk.sv
module nanq_unit_chk #(
    parameter int unsigned EXP_W  = nanq_pkg::DP_EXP_W,
    parameter int unsigned FRAC_W = nanq_pkg::DP_FRAC_W,
    localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [OP_W-1:0] in_data,
    input logic            in_quiet,
    input logic            in_mode2008,
    input logic            out_valid,
    input logic            out_ready,
    input logic [OP_W-1:0] out_data,
    input logic            out_is_nan,
    input logic            out_is_snan,
    input logic            clr_invalid,
    input logic            out_invalid
);
    logic in_snan_c;
    logic out_nan_c;
    logic take;

    always_comb begin
        in_snan_c = (&in_data[OP_W-2:FRAC_W]) && (|in_data[FRAC_W-1:0])
                    && (in_data[FRAC_W-1] ^ in_mode2008);
        out_nan_c = (&out_data[OP_W-2:FRAC_W]) && (|out_data[FRAC_W-1:0]);
        take      = in_valid && in_ready;
    end

    assert_quiet_only_snan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_quiet |-> in_snan_c);

    assert_invalid_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_quiet |=> out_invalid);

    assert_invalid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid && !clr_invalid |=> out_invalid);

    assert_invalid_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_invalid && !(take && in_quiet) |=> !out_invalid);

    assert_accept_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid);

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_is_nan) && $stable(out_is_snan));

    assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    assert_nan_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_is_nan == out_nan_c);

    assert_snan_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_is_snan |-> out_is_nan);

    assert_sign_exp_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_data[OP_W-1:FRAC_W] == $past(in_data[OP_W-1:FRAC_W]));

endmodule

bind nanq_unit nanq_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_quiet   (in_quiet),
    .in_mode2008(in_mode2008),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_is_nan (out_is_nan),
    .out_is_snan(out_is_snan),
    .clr_invalid(clr_invalid),
    .out_invalid(out_invalid)
);

// File: tb/nanq_unit_test.sv
module nanq_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        in_quiet = 1'b0;
    logic        in_mode2008 = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic        out_is_nan;
    logic        out_is_snan;
    logic        clr_invalid = 1'b0;
    logic        out_invalid;

    int checks = 0;
    int failures = 0;
    logic inv_model = 1'b0;

    always #2 clk = ~clk;

    nanq_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_quiet(in_quiet), .in_mode2008(in_mode2008),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_is_nan(out_is_nan), .out_is_snan(out_is_snan),
        .clr_invalid(clr_invalid), .out_invalid(out_invalid)
    );

    localparam int NV = 11;
    localparam logic [63:0] V_OP [NV] = '{
        64'h7FF0000000000000, 64'h0000000000000000, 64'h3FF0000000000000,
        64'h7FF8000000000000, 64'h7FF8000000000000, 64'h7FF8000000000001,
        64'hFFF0000000000001, 64'h7FF4000000000000, 64'h7FF0000000000001,
        64'hFFFFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF };
    localparam logic V_MODE [NV] = '{0,1,0,1,0,0,1,0,0,0,1};
    localparam logic V_Q    [NV] = '{0,0,0,0,1,1,1,0,0,1,0};
    localparam logic [63:0] V_EXP [NV] = '{
        64'h7FF0000000000000, 64'h0000000000000000, 64'h3FF0000000000000,
        64'h7FF8000000000000, 64'h7FF4000000000000, 64'h7FF0000000000001,
        64'hFFF8000000000001, 64'h7FF4000000000000, 64'h7FF0000000000001,
        64'hFFF7FFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF };
    localparam logic V_NAN  [NV] = '{0,0,0,1,1,1,1,1,1,1,0};
    localparam logic V_SNAN [NV] = '{0,0,0,0,1,1,1,0,0,1,0};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic m_nan(input logic [63:0] op);
        return (op[62:52] == 11'h7FF) && (op[51:0] != 52'd0);
    endfunction

    function automatic logic m_snan(input logic [63:0] op, input logic mode);
        return m_nan(op) && (op[51] != mode);
    endfunction

    function automatic logic [63:0] m_quiet(input logic [63:0] op, input logic mode);
        logic [63:0] r;
        r = op;
        if (mode) begin
            r[51] = 1'b1;
        end else begin
            r[51] = 1'b0;
            if (r[51:0] == 52'd0) r[50] = 1'b1;
        end
        return r;
    endfunction

    task automatic send(input logic [63:0] op, input logic mode, input logic q, input logic clr);
        @(negedge clk);
        in_data = op; in_mode2008 = mode; in_quiet = q; clr_invalid = clr;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_quiet = 1'b0; clr_invalid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 out_invalid", 64'(out_invalid), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;

        // table: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            send(V_OP[i], V_MODE[i], V_Q[i], 1'b0);
            inv_model = inv_model | V_Q[i];
            chk("R8 out_valid", 64'(out_valid), 64'd1);
            chk(V_Q[i] ? (V_MODE[i] ? "R5 data" : "R6 data") : "R4 data", out_data, V_EXP[i]);
            chk("R2 is_nan", 64'(out_is_nan), 64'(V_NAN[i]));
            chk("R3 is_snan", 64'(out_is_snan), 64'(V_SNAN[i]));
            chk("R7 invalid", 64'(out_invalid), 64'(inv_model));
        end

        // R7 clear, then set wins over clear
        @(negedge clk); clr_invalid = 1'b1;
        @(negedge clk); clr_invalid = 1'b0;
        chk("R7 cleared", 64'(out_invalid), 64'd0);
        send(64'h7FF0000000000002, 1'b1, 1'b1, 1'b1);
        chk("R7 set wins", 64'(out_invalid), 64'd1);
        chk("R5 data", out_data, 64'h7FF8000000000002);
        @(negedge clk); clr_invalid = 1'b1;
        @(negedge clk); clr_invalid = 1'b0;
        chk("R7 cleared again", 64'(out_invalid), 64'd0);

        // R8 R9 backpressure
        @(negedge clk);
        out_ready = 1'b0;
        in_data = 64'h7FF8000000000000; in_mode2008 = 1'b1; in_quiet = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        chk("R9 ready low while stalled", 64'(in_ready), 64'd0);
        chk("R8 first result", out_data, 64'h7FF8000000000000);
        in_data = 64'h7FF0000000000001; in_quiet = 1'b1;
        @(negedge clk);
        chk("R8 held", out_data, 64'h7FF8000000000000);
        chk("R7 stalled offer not taken", 64'(out_invalid), 64'd0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_quiet = 1'b0;
        chk("R9 taken after release", out_data, 64'h7FF8000000000001);
        chk("R7 invalid after release", 64'(out_invalid), 64'd1);
        inv_model = 1'b1;
        @(negedge clk);
        chk("R9 drained", 64'(out_valid), 64'd0);

        // random sweep
        for (int k = 0; k < 300; k++) begin
            logic [63:0] op;
            logic mode, q;
            int cls;
            op = {$urandom(), $urandom()};
            cls = $urandom_range(0, 3);
            mode = 1'($urandom());
            if (cls == 0) begin
                op[62:52] = 11'h7FF;
                if (op[51:0] == 52'd0) op[0] = 1'b1;
            end else if (cls == 1) begin
                op[62:0] = 63'h7FF0000000000000;
            end else if (cls == 2) begin
                op[62:0] = '0;
            end else if (op[62:52] == 11'h7FF || op[62:52] == 11'h000) begin
                op[62:52] = 11'h400;
            end
            q = m_snan(op, mode) && 1'($urandom());
            send(op, mode, q, 1'b0);
            inv_model = inv_model | q;
            chk(q ? "R5/R6 random data" : "R4 random data", out_data, q ? m_quiet(op, mode) : op);
            chk("R2 random", 64'(out_is_nan), 64'(m_nan(op)));
            chk("R3 random", 64'(out_is_snan), 64'(m_snan(op, mode)));
            chk("R7 random", 64'(out_invalid), 64'(inv_model));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule